// File: doc/BRIEF.md
# Page Write Loader with Retriggerable Load Timeout

This block is a clock-driven behavioural model of the write side of one byte-wide lane of a nonvolatile memory. Byte-write strobes carry an address and a data byte. The block collects them in a page buffer of up to 2**PAGE_BITS bytes, indexed by the low address bits. Every accepted strobe restarts a quiet-gap timer. When the timer runs out, the block enters a programming phase of fixed length. At the end of that phase every loaded byte of the page is written to the backing array in one step.

While programming is under way, a host can poll the location it wrote last. Bit 7 of that location reads back inverted until the commit is done. Any other location reads all ones during that phase. Outside programming, the read port returns array contents combinationally. The load gap and the programming time are parameters counted in clock cycles, so short values can stand in for the real microsecond and millisecond intervals.

Top module: `pgw_loader`

## Requirements
- R1: After synchronous reset, `busy` and `loading` are 0 and every array location reads 8'hFF.
- R2: A strobe (`wr_en`=1 while `busy`=0) stores `wr_data` in the buffer slot given by `wr_addr[PAGE_BITS-1:0]`, and `loading` is 1 from the next cycle on.
- R3: Each accepted strobe restarts the timeout. Programming starts (`busy` rises) exactly LOAD_CYC clock edges after the edge that sampled the last strobe, and not before. Strobes spaced closer than that keep adding to the same page.
- R4: Programming lasts exactly PROG_CYC cycles whatever the number of loaded bytes. On its final edge the page is written to the array, and `busy` falls with `loading` 0.
- R5: While `busy`=1, reading the last written location returns that byte with bit 7 inverted and bits 6..0 true. After `busy` falls, the true byte is returned.
- R6: While `busy`=1, reading any other address returns 8'hFF.
- R7: Strobes that arrive while `busy`=1 are ignored: they neither start a new load nor change the array.
- R8: Page slots that received no byte leave their array locations unchanged at commit.
- R9: The page address (`wr_addr` bits above PAGE_BITS) is taken from the first strobe of a load. The upper bits of later strobes in the same load are ignored.
- R10: While `loading`=1, reads return the old array contents, not the buffered bytes.
- R11: A second strobe to the same slot within one load replaces the earlier byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte-write strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Byte address of the strobe |
| wr_data | input | 8 | Byte to load |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte, or polling value while programming |
| busy | output | 1 | Programming phase in progress |
| loading | output | 1 | Page load window open |

## Verification
The hardest conditions to reach from the ports are a strobe that lands while programming is under way, and a strobe whose upper address bits stray from the page being loaded. Both happen only inside narrow phases that are counted in cycles. The stimulus loads a page with strobes spaced just under the timeout, one of them carrying a foreign page number and one rewriting a slot. It then counts edges to issue a strobe and polling reads while `busy` is high. After the commit, reads of the foreign raw address, of the unloaded slots and of the rejected strobe's address show that none of them reached the array.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    // value seen on a poll of the last written byte while programming
    function automatic logic [BYTE_W-1:0] poll_byte(input logic [BYTE_W-1:0] d);
        return {~d[BYTE_W-1], d[BYTE_W-2:0]};
    endfunction

endpackage

// File: rtl/pgw_timer.sv
module pgw_timer
    import pgw_pkg::*;
#(
    parameter int LOAD_CYC = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    output phase_e phase,
    output logic   commit
);
    localparam int MAXC = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_PROG: begin
                    if (cnt == CW'(PROG_CYC - 1)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (strobe) begin
                        phase <= PH_LOAD;
                        cnt   <= '0;
                    end else if (phase == PH_LOAD) begin
                        if (cnt == CW'(LOAD_CYC - 1)) begin
                            phase <= PH_PROG;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign commit = (phase == PH_PROG) && (cnt == CW'(PROG_CYC - 1));

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 accept,
    input  logic                                 first,
    input  logic                                 clear,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [BYTE_W-1:0]                    wr_data,
    output logic [(1<<PAGE_BITS)-1:0][BYTE_W-1:0] page_data,
    output logic [(1<<PAGE_BITS)-1:0]            page_mask,
    output logic [ADDR_W-PAGE_BITS-1:0]          page_base,
    output logic [ADDR_W-1:0]                    last_addr,
    output logic [BYTE_W-1:0]                    last_data
);
    localparam int BASE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_BITS-1:0] off;
    logic [BASE_W-1:0]    base_nxt;

    assign off      = wr_addr[PAGE_BITS-1:0];
    assign base_nxt = first ? wr_addr[ADDR_W-1:PAGE_BITS] : page_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_data <= '0;
            page_mask <= '0;
            page_base <= '0;
            last_addr <= '0;
            last_data <= '0;
        end else if (clear) begin
            page_mask <= '0;
        end else if (accept) begin
            page_base       <= base_nxt;
            page_data[off]  <= wr_data;
            page_mask[off]  <= 1'b1;
            last_addr       <= {base_nxt, off};
            last_data       <= wr_data;
        end
    end

endmodule

// File: rtl/pgw_array.sv
module pgw_array
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 commit,
    input  logic [(1<<PAGE_BITS)-1:0][BYTE_W-1:0] page_data,
    input  logic [(1<<PAGE_BITS)-1:0]            page_mask,
    input  logic [ADDR_W-PAGE_BITS-1:0]          page_base,
    input  logic                                 busy,
    input  logic [ADDR_W-1:0]                    last_addr,
    input  logic [BYTE_W-1:0]                    last_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [BYTE_W-1:0]                    rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_BITS;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (page_mask[i]) mem[{page_base, PAGE_BITS'(i)}] <= page_data[i];
            end
        end
    end

    always_comb begin
        if (busy) rd_data = (rd_addr == last_addr) ? poll_byte(last_data) : '1;
        else      rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/pgw_loader.sv
module pgw_loader
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 6,
    parameter int LOAD_CYC  = 7500,
    parameter int PROG_CYC  = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              loading
);
    localparam int PAGE   = 1 << PAGE_BITS;
    localparam int BASE_W = ADDR_W - PAGE_BITS;

    phase_e                        phase;
    logic                          commit;
    logic                          accept;
    logic [PAGE-1:0][BYTE_W-1:0]   page_data;
    logic [PAGE-1:0]               page_mask;
    logic [BASE_W-1:0]             page_base;
    logic [ADDR_W-1:0]             last_addr;
    logic [BYTE_W-1:0]             last_data;

    assign busy    = (phase == PH_PROG);
    assign loading = (phase == PH_LOAD);
    assign accept  = wr_en && !busy;

    pgw_timer #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) u_timer (
        .clk(clk), .rst(rst), .strobe(accept), .phase(phase), .commit(commit)
    );

    pgw_page_buf #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk(clk), .rst(rst), .accept(accept), .first(phase == PH_IDLE),
        .clear(commit), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_data(page_data), .page_mask(page_mask), .page_base(page_base),
        .last_addr(last_addr), .last_data(last_data)
    );

    pgw_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_array (
        .clk(clk), .rst(rst), .commit(commit), .page_data(page_data),
        .page_mask(page_mask), .page_base(page_base), .busy(busy),
        .last_addr(last_addr), .last_data(last_data), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic              loading
);
    logic [ADDR_W-PAGE_BITS-1:0] trk_page;
    logic [ADDR_W-1:0]           trk_addr;
    logic [7:0]                  trk_dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_page <= '0;
            trk_addr <= '0;
            trk_dat  <= '0;
        end else if (wr_en && !busy) begin
            if (!loading) trk_page <= wr_addr[ADDR_W-1:PAGE_BITS];
            trk_addr <= {(loading ? trk_page : wr_addr[ADDR_W-1:PAGE_BITS]),
                         wr_addr[PAGE_BITS-1:0]};
            trk_dat  <= wr_data;
        end
    end

    // R2
    strobe_opens_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> loading);

    // R3
    prog_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(loading));

    // R4
    prog_ends_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !loading);

    // R5
    poll_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_addr == trk_addr) |-> (rd_data == {~trk_dat[7], trk_dat[6:0]}));

    // R6
    other_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_addr != trk_addr) |-> (rd_data == 8'hFF));

    // R7
    busy_strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> !loading);

endmodule

bind pgw_loader pgw_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .loading(loading)
);

// File: tb/sim_pgw_loader.sv
`timescale 1ns/1ps
module sim_pgw_loader;

    localparam int ADDR_W = 10;
    localparam int LC     = 8;
    localparam int PC     = 40;
    localparam int NV     = 6;

    // {wr_addr[9:0], wr_data[7:0], expected read-back at committed location[7:0]}
    localparam logic [25:0] VEC [NV] = '{
        {10'h0C0, 8'hAA, 8'hAA},
        {10'h0C1, 8'h55, 8'h55},
        {10'h0C5, 8'h3C, 8'h81},   // slot rewritten by next entry (R11)
        {10'h0C5, 8'h81, 8'h81},
        {10'h17F, 8'h7E, 8'h7E},   // foreign page bits, lands in page 3 (R9)
        {10'h0E0, 8'h96, 8'h96}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              busy;
    logic              loading;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pgw_loader #(.ADDR_W(ADDR_W), .PAGE_BITS(6), .LOAD_CYC(LC), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .loading(loading)
    );

    task automatic chk(input logic [9:0] act, input logic [9:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk({2'b0, rd_data}, {2'b0, exp}, tag);
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy, 0, "R1 busy after reset");
        chk(loading, 0, "R1 loading after reset");
        rd(10'h0C0, 8'hFF, "R1 array erased");
        rd(10'h3FF, 8'hFF, "R1 array erased top");

        // page load, strobes spaced LC-2 idle cycles apart
        for (int i = 0; i < NV; i++) begin
            if (i > 0) begin
                chk(busy, 0, "R3 no program inside gap");
                chk(loading, 1, "R2 load window open");
            end
            wr(VEC[i][25:16], VEC[i][15:8]);
            if (i == 2) rd(10'h0C0, 8'hFF, "R10 old contents while loading");
            if (i < NV - 1) repeat (LC - 2) @(negedge clk);
        end
        repeat (LC - 1) @(negedge clk);
        chk(busy, 0, "R3 timeout not yet expired");
        @(negedge clk);
        chk(busy, 1, "R3 programming starts on expiry");
        rd(10'h0E0, 8'h16, "R5 poll inverted bit 7");
        rd(10'h0C0, 8'hFF, "R6 other address all ones");
        wr(10'h0C3, 8'h11);
        chk(loading, 0, "R7 strobe while busy ignored");
        repeat (PC - 2) @(negedge clk);
        chk(busy, 1, "R4 still programming");
        @(negedge clk);
        chk(busy, 0, "R4 programming done");
        chk(loading, 0, "R4 idle after commit");
        rd(10'h0E0, 8'h96, "R5 true data after commit");

        for (int i = 0; i < NV; i++)
            rd({VEC[0][25:22], VEC[i][21:16]}, VEC[i][7:0], "R2 R9 R11 committed byte");
        rd(10'h0C2, 8'hFF, "R8 unloaded slot unchanged");
        rd(10'h17F, 8'hFF, "R9 raw foreign address untouched");
        rd(10'h0C3, 8'hFF, "R7 busy strobe not written");

        // single-byte page: same programming length
        wr(10'h200, 8'h42);
        repeat (LC) @(negedge clk);
        chk(busy, 1, "R4 single byte program start");
        rd(10'h200, 8'hC2, "R5 poll single byte");
        repeat (PC - 1) @(negedge clk);
        chk(busy, 1, "R4 single byte full length");
        @(negedge clk);
        chk(busy, 0, "R4 single byte done");
        rd(10'h200, 8'h42, "R4 single byte committed");
        rd(10'h201, 8'hFF, "R8 neighbour unchanged");
        rd(10'h0C0, 8'hAA, "R8 earlier page kept");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule